// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves program-flow opcodes of an 8-bit processor with a 16-bit address space. The caller presents the opcode byte and the current condition flags. It also presents the program counter of the instruction, the HL register, the immediate that follows the opcode (one displacement byte or a 16-bit address) and the return address already read from the stack. From these the block decides whether control transfers and produces the address of the next instruction.

Every decision is made in one combinational pass and captured in an output register. The result appears one clock after the request, with a valid strobe. Two single-bit requests tell the surrounding datapath to save the return address (calls and restarts) or to discard the top of stack (returns). Stack-pointer arithmetic and memory traffic stay outside.

Absolute forms use a three-bit condition field that can test zero, carry, parity/overflow and sign. Relative forms use a two-bit field limited to zero and carry.

Top module: `brc_flow_unit`

## Requirements
- R1: `flags_i` is {S, Z, PV, C} with S in bit 3 and C in bit 0. For a conditional jump 11ccc010, ccc=000 is taken when Z=0, 001 when Z=1, 010 when C=0 and 011 when C=1. A taken jump gives next_pc = imm_i; an untaken one gives pc_i+3.
- R2: ccc=100 is taken when PV=0 and 101 when PV=1. ccc=110 is taken when S=0 and 111 when S=1. The same mapping applies to conditional calls and returns.
- R3: For opcode 0x18 (always taken) and 001cc000, cc picks the same four tests as ccc 000..011. The target is pc_i+2 plus imm_i[7:0] sign-extended, modulo 2^16. An untaken jump gives pc_i+2.
- R4: Opcode 0xC3 is always taken, with next_pc = imm_i.
- R5: Opcode 0xCD and 11ccc100 are calls. When taken, next_pc = imm_i and push_ret=1. When untaken, next_pc = pc_i+3 and push_ret=0.
- R6: Opcode 0xC9 and 11ccc000 are returns. When taken, next_pc = ret_addr_i and pop_ret=1. When untaken, next_pc = pc_i+1 and pop_ret=0.
- R7: Opcode 0xE9 is always taken, with next_pc = hl_i and neither push_ret nor pop_ret.
- R8: Opcode 11bbb111 is always taken, with next_pc = bbb*8 zero-extended and push_ret=1.
- R9: Any other opcode, including 0x10, gives taken=0, push_ret=0, pop_ret=0 and next_pc = pc_i+1 modulo 2^16.
- R10: Results appear with out_valid exactly one clock after a cycle with in_valid=1. After a cycle without in_valid, out_valid=0 and next_pc keeps its value.
- R11: push_ret and pop_ret are never both 1, and either one implies taken.
- R12: While rst_n is low, out_valid, taken, push_ret and pop_ret are 0 and next_pc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode_i | input | 8 | Opcode byte |
| flags_i | input | 4 | {S, Z, PV, C} |
| pc_i | input | 16 | Address of the opcode |
| hl_i | input | 16 | HL register |
| imm_i | input | 16 | Immediate; bits 7:0 hold the displacement for relative forms |
| ret_addr_i | input | 16 | Return address popped from the stack |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Control transfers |
| next_pc | output | 16 | Next instruction address |
| push_ret | output | 1 | Save the return address |
| pop_ret | output | 1 | Discard the top of stack |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, an 8-bit displacement and restart vectors spaced 8 bytes apart. With these widths the bench can reach the address wrap at both ends. It drives relative targets across 0xFFFF and below 0x0000, and sequential addresses out of 0xFFFF. It also covers the most negative and most positive displacements and all eight restart vectors.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [3:0] {
    CLS_NONE,
    CLS_REL,
    CLS_ABS,
    CLS_CALL,
    CLS_RET,
    CLS_VIA_HL,
    CLS_VECTOR
  } flow_cls_e;

  typedef struct packed {
    logic s;
    logic z;
    logic pv;
    logic c;
  } flag_set_t;

  typedef struct packed {
    flow_cls_e  cls;
    logic       cond_en;   // 1: a test applies
    logic [2:0] cond;      // unified three-bit test code
    logic [1:0] len;       // instruction length in bytes
    logic [2:0] vec;       // restart vector index
  } flow_dec_t;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [2:0] cond,
  input  flag_set_t  flags,
  output logic       pass
);
  localparam int NTAP = 4;

  // tap order matches cond[2:1]: zero, carry, parity, sign
  logic [NTAP-1:0] tap;
  assign tap[0] = flags.z;
  assign tap[1] = flags.c;
  assign tap[2] = flags.pv;
  assign tap[3] = flags.s;

  logic [NTAP-1:0] hit;
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign hit[i] = (cond[2:1] == i[1:0]) && (tap[i] == cond[0]);
  end

  assign pass = |hit;
endmodule

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
(
  input  logic [7:0] op,
  output flow_dec_t  dec
);
  always_comb begin
    dec.cls     = CLS_NONE;
    dec.cond_en = 1'b0;
    dec.cond    = op[5:3];
    dec.len     = 2'd1;
    dec.vec     = op[5:3];
    if (op == 8'h18) begin
      dec.cls = CLS_REL;
      dec.len = 2'd2;
    end else if (op[7:5] == 3'b001 && op[2:0] == 3'b000) begin
      dec.cls     = CLS_REL;
      dec.len     = 2'd2;
      dec.cond_en = 1'b1;
      dec.cond    = {1'b0, op[4:3]};
    end else if (op == 8'hC3) begin
      dec.cls = CLS_ABS;
      dec.len = 2'd3;
    end else if (op == 8'hCD) begin
      dec.cls = CLS_CALL;
      dec.len = 2'd3;
    end else if (op == 8'hC9) begin
      dec.cls = CLS_RET;
    end else if (op == 8'hE9) begin
      dec.cls = CLS_VIA_HL;
    end else if (op[7:6] == 2'b11) begin
      unique case (op[2:0])
        3'b000: begin
          dec.cls     = CLS_RET;
          dec.cond_en = 1'b1;
        end
        3'b010: begin
          dec.cls     = CLS_ABS;
          dec.cond_en = 1'b1;
          dec.len     = 2'd3;
        end
        3'b100: begin
          dec.cls     = CLS_CALL;
          dec.cond_en = 1'b1;
          dec.len     = 2'd3;
        end
        3'b111: dec.cls = CLS_VECTOR;
        default: dec.cls = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/brc_target.sv
module brc_target
  import brc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DISP_W    = 8,
  parameter int VEC_SHIFT = 3
) (
  input  flow_dec_t          dec,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  hl,
  input  logic [ADDR_W-1:0]  imm,
  input  logic [ADDR_W-1:0]  ret_addr,
  output logic [ADDR_W-1:0]  seq_pc,
  output logic [ADDR_W-1:0]  dest_pc
);
  localparam int VEC_PAD = ADDR_W - 3 - VEC_SHIFT;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] len_ext;

  assign disp_ext = {{(ADDR_W-DISP_W){imm[DISP_W-1]}}, imm[DISP_W-1:0]};
  assign len_ext  = {{(ADDR_W-2){1'b0}}, dec.len};
  assign seq_pc   = pc + len_ext;

  always_comb begin
    unique case (dec.cls)
      CLS_REL:    dest_pc = seq_pc + disp_ext;
      CLS_ABS,
      CLS_CALL:   dest_pc = imm;
      CLS_RET:    dest_pc = ret_addr;
      CLS_VIA_HL: dest_pc = hl;
      CLS_VECTOR: dest_pc = {{VEC_PAD{1'b0}}, dec.vec, {VEC_SHIFT{1'b0}}};
      default:    dest_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/brc_flow_unit.sv
module brc_flow_unit
  import brc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DISP_W    = 8,
  parameter int VEC_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  output logic              out_valid,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              push_ret,
  output logic              pop_ret
);
  flow_dec_t         dec;
  logic              cond_ok;
  logic [ADDR_W-1:0] seq_pc, dest_pc;

  brc_decode u_dec (.op(opcode_i), .dec(dec));

  brc_cond_eval u_cond (
    .cond (dec.cond),
    .flags(flag_set_t'(flags_i)),
    .pass (cond_ok)
  );

  brc_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .VEC_SHIFT(VEC_SHIFT)) u_tgt (
    .dec(dec), .pc(pc_i), .hl(hl_i), .imm(imm_i), .ret_addr(ret_addr_i),
    .seq_pc(seq_pc), .dest_pc(dest_pc)
  );

  // next-state
  logic              take_d, push_d, pop_d;
  logic [ADDR_W-1:0] npc_d;

  always_comb begin
    take_d = (dec.cls != CLS_NONE) && (!dec.cond_en || cond_ok);
    npc_d  = take_d ? dest_pc : seq_pc;
    push_d = take_d && (dec.cls == CLS_CALL || dec.cls == CLS_VECTOR);
    pop_d  = take_d && (dec.cls == CLS_RET);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken    <= 1'b0;
      next_pc  <= '0;
      push_ret <= 1'b0;
      pop_ret  <= 1'b0;
    end else if (in_valid) begin
      taken    <= take_d;
      next_pc  <= npc_d;
      push_ret <= push_d;
      pop_ret  <= pop_d;
    end
  end

  // R10: latency and hold
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_pc)));
  // R11: stack requests exclusive and only on taken
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_ret, pop_ret}));
  a_r11_req_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ret || pop_ret) |-> taken);
  // R7: jump through HL
  a_r7_via_hl: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode_i == 8'hE9) |=> (taken && next_pc == $past(hl_i)));
  // R8: restart vector
  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode_i[7:6] == 2'b11 && opcode_i[2:0] == 3'b111) |=>
      (push_ret && next_pc[2:0] == 3'b000 && next_pc[5:3] == $past(opcode_i[5:3])));
  // R4: unconditional absolute jump
  a_r4_abs: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode_i == 8'hC3) |=> (taken && next_pc == $past(imm_i)));
endmodule

// File: tb/sim_brc_flow_unit.sv
module sim_brc_flow_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [3:0]  flags_i = 4'h0;
  logic [15:0] pc_i = '0, hl_i = '0, imm_i = '0, ret_addr_i = '0;
  logic        out_valid, taken, push_ret, pop_ret;
  logic [15:0] next_pc;

  always #2.5 clk = ~clk;

  brc_flow_unit u0 (.*);

  typedef struct {
    logic        tk;
    logic [15:0] pc;
    logic        pu;
    logic        po;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, sent = 0, got = 0;
  bit done = 1'b0;

  function automatic bit cond_ok(input logic [2:0] c, input logic [3:0] f);
    logic v;
    case (c[2:1])
      2'd0: v = f[2];   // Z
      2'd1: v = f[0];   // C
      2'd2: v = f[1];   // PV
      default: v = f[3]; // S
    endcase
    return v == c[0];
  endfunction

  task automatic drive(input logic [7:0] op, input logic [3:0] f,
                       input logic [15:0] pc, input logic [15:0] imm,
                       input logic [15:0] hl, input logic [15:0] ra);
    exp_t e;
    logic [15:0] dext;
    dext = {{8{imm[7]}}, imm[7:0]};
    e.pu = 0; e.po = 0;
    if (op == 8'h18) begin
      e.tk = 1; e.pc = pc + 16'd2 + dext; e.req = "R3";
    end else if (op[7:5] == 3'b001 && op[2:0] == 3'b000) begin
      e.tk = cond_ok({1'b0, op[4:3]}, f);
      e.pc = e.tk ? pc + 16'd2 + dext : pc + 16'd2; e.req = "R3";
    end else if (op == 8'hC3) begin
      e.tk = 1; e.pc = imm; e.req = "R4";
    end else if (op == 8'hCD) begin
      e.tk = 1; e.pc = imm; e.pu = 1; e.req = "R5";
    end else if (op == 8'hC9) begin
      e.tk = 1; e.pc = ra; e.po = 1; e.req = "R6";
    end else if (op == 8'hE9) begin
      e.tk = 1; e.pc = hl; e.req = "R7";
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b010) begin
      e.tk = cond_ok(op[5:3], f); e.pc = e.tk ? imm : pc + 16'd3;
      e.req = op[5] ? "R2" : "R1";
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b100) begin
      e.tk = cond_ok(op[5:3], f); e.pc = e.tk ? imm : pc + 16'd3;
      e.pu = e.tk; e.req = "R5";
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b000) begin
      e.tk = cond_ok(op[5:3], f); e.pc = e.tk ? ra : pc + 16'd1;
      e.po = e.tk; e.req = "R6";
    end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin
      e.tk = 1; e.pc = {10'd0, op[5:3], 3'd0}; e.pu = 1; e.req = "R8";
    end else begin
      e.tk = 0; e.pc = pc + 16'd1; e.req = "R9";
    end
    @(negedge clk);
    in_valid = 1; opcode_i = op; flags_i = f; pc_i = pc; imm_i = imm;
    hl_i = hl; ret_addr_i = ra;
    exp_q.push_back(e);
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      opcode_i = 8'hC3;
      imm_i = 16'hDEAD;
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic [15:0] last_pc;
    bit have_last;
    bit prev_in;
    have_last = 0;
    prev_in = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (out_valid != prev_in) begin
          checks++; errors++;
          $display("FAIL R10 out_valid=%0b expected %0b", out_valid, prev_in);
        end
        if (!out_valid && have_last) begin
          checks++;
          if (next_pc != last_pc) begin
            errors++;
            $display("FAIL R10 hold next_pc=%h expected %h", next_pc, last_pc);
          end
        end
        if (out_valid) begin
          exp_t e;
          got++;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected result next_pc=%h expected none", next_pc);
          end else begin
            e = exp_q.pop_front();
            if (taken !== e.tk || next_pc !== e.pc || push_ret !== e.pu || pop_ret !== e.po) begin
              errors++;
              $display("FAIL %s got tk=%b pc=%h push=%b pop=%b expected tk=%b pc=%h push=%b pop=%b",
                       e.req, taken, next_pc, push_ret, pop_ret, e.tk, e.pc, e.pu, e.po);
            end
            checks++;
            if (push_ret && pop_ret || ((push_ret || pop_ret) && !taken)) begin
              errors++;
              $display("FAIL R11 push=%b pop=%b taken=%b expected exclusive and taken",
                       push_ret, pop_ret, taken);
            end
          end
          last_pc = next_pc;
          have_last = 1;
        end
      end
      prev_in = in_valid;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (out_valid !== 0 || taken !== 0 || next_pc !== 16'h0 || push_ret !== 0 || pop_ret !== 0) begin
      errors++;
      $display("FAIL R12 v=%b tk=%b pc=%h pu=%b po=%b expected all zero",
               out_valid, taken, next_pc, push_ret, pop_ret);
    end
    rst_n = 1;
    idle(2);
    // R1, R2: every ccc against flag patterns
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f += 5)
        drive({2'b11, c[2:0], 3'b010}, f[3:0], 16'h4000 + 16'(c), 16'hBEEF, 16'h0, 16'h0);
    drive(8'hC2, 4'b0100, 16'hFFFE, 16'h1234, 0, 0); // R1 untaken wraps to 0001
    // R3: relative forms
    drive(8'h18, 4'h0, 16'h1000, 16'h007F, 0, 0);
    drive(8'h18, 4'h0, 16'h1000, 16'h0080, 0, 0);
    drive(8'h18, 4'h0, 16'hFFF0, 16'h0020, 0, 0);   // wrap upward
    drive(8'h18, 4'h0, 16'h0001, 16'h00F0, 0, 0);   // wrap downward
    drive(8'h18, 4'h0, 16'h2000, 16'hFFFE, 0, 0);   // self-loop
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 16; f += 3)
        drive({3'b001, c[1:0], 3'b000}, f[3:0], 16'h3000, 16'h0010, 0, 0);
    // R4
    drive(8'hC3, 4'h0, 16'h5555, 16'hA5A5, 0, 0);
    // R5: calls
    drive(8'hCD, 4'h0, 16'h6000, 16'h8000, 0, 0);
    for (int c = 0; c < 8; c++) begin
      drive({2'b11, c[2:0], 3'b100}, 4'h0, 16'h6100, 16'h0123, 0, 0);
      drive({2'b11, c[2:0], 3'b100}, 4'hF, 16'h6100, 16'h0123, 0, 0);
    end
    // R6: returns
    drive(8'hC9, 4'h0, 16'h7000, 0, 0, 16'h1357);
    for (int c = 0; c < 8; c++) begin
      drive({2'b11, c[2:0], 3'b000}, 4'h0, 16'h7100, 0, 0, 16'h2468);
      drive({2'b11, c[2:0], 3'b000}, 4'hF, 16'hFFFF, 0, 0, 16'h2468);
    end
    idle(3);
    // R7
    drive(8'hE9, 4'h0, 16'h8000, 16'h1111, 16'hCAFE, 16'h2222);
    // R8: all vectors
    for (int b = 0; b < 8; b++)
      drive({2'b11, b[2:0], 3'b111}, 4'h0, 16'h9000, 16'hFFFF, 0, 0);
    // R9: non-flow opcodes
    drive(8'h00, 4'hF, 16'hFFFF, 16'h1234, 16'h4321, 16'h5678);
    drive(8'h10, 4'h0, 16'h0100, 16'h0005, 0, 0);
    drive(8'h76, 4'h0, 16'h0200, 0, 0, 0);
    drive(8'hCB, 4'h0, 16'h0300, 0, 0, 0);
    drive(8'hED, 4'h0, 16'h0400, 0, 0, 0);
    drive(8'hC1, 4'hF, 16'h0500, 0, 0, 0);
    idle(4);
    checks++;
    if (exp_q.size() != 0 || got != sent) begin
      errors++;
      $display("FAIL R10 results=%0d expected %0d", got, sent);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule